// File: doc/BRIEF.md
# Serial FPGA Configuration Sequencer

This block loads a bitstream into a downstream FPGA through the target's serial slave configuration port. A one-cycle start pulse begins the sequence. The block pulls the target's active-low reset and the active-low slave select low together and holds reset for a minimum time. It then releases reset and waits for the target to clear its configuration memory, checking that the target's done flag is still low at the end of that wait.

Next it sends one dummy byte with slave select raised and lowers slave select again. It streams the image, which arrives as bytes on a ready/valid interface with a last-byte marker, MSB first in SPI mode 0. After the image it raises slave select and clocks 13 zero bytes, then checks that the done flag has gone high. If it has, the block clocks 13 more zero bytes so the target activates its user I/O, and then reports success. Both minimum delays are computed from a clock-frequency parameter and rounded up. The serial clock is the system clock divided by an even parameter.

Top module: `fpga_cfg_seq`

## Requirements
- R1: After reset, cfg_rst_no=1, cfg_ss_no=1, cfg_sck_o=0, busy_o=0 and ok_o, err_reset_o, err_done_o are all 0.
- R2: A start pulse while idle drives cfg_rst_no and cfg_ss_no low in the same cycle. cfg_rst_no stays low for at least ceil(CLK_HZ*RST_NS/1e9) cycles and falls exactly once per sequence.
- R3: After cfg_rst_no rises, cfg_ss_no stays low with no serial clock edge for at least ceil(CLK_HZ*WAIT_US/1e6) cycles before any dummy or data clock.
- R4: If cfg_done_i is high at the end of that wait, the block sets err_reset_o, issues no serial clock edge and returns to idle (busy_o=0).
- R5: After the wait, cfg_ss_no is high for exactly 8*PRE_BYTES rising serial clock edges with cfg_sdo_o=0. Then cfg_ss_no goes low.
- R6: Image bytes are shifted MSB first in mode 0: the clock idles low, cfg_sdo_o changes only while the clock is low, and the target samples on the rising edge. cfg_ss_no stays low until the byte marked last has been fully shifted.
- R7: While byte_valid_i is low in the middle of the image, cfg_sck_o stays low and cfg_ss_no stays low.
- R8: After the last image byte, cfg_ss_no rises and 8*POST_BYTES dummy clocks with cfg_sdo_o=0 follow. If cfg_done_i is then low, err_done_o is set and the block goes idle.
- R9: If cfg_done_i is high after the trailing dummies, 8*ACT_BYTES further dummy clocks follow with cfg_ss_no still high, and then ok_o is set. At most one of ok_o, err_reset_o, err_done_o is ever high.
- R10: A start pulse while busy_o is high has no effect on the sequence.
- R11: Consecutive rising serial clock edges are at least SCK_DIV system cycles apart, and the serial clock is low whenever no byte is shifting.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | System clock |
| rst_ni | input | 1 | Active-low asynchronous reset |
| start_i | input | 1 | Start pulse |
| byte_i | input | 8 | Bitstream byte |
| byte_valid_i | input | 1 | Byte valid |
| byte_last_i | input | 1 | Marks the final bitstream byte |
| byte_ready_o | output | 1 | Byte accepted when high together with valid |
| cfg_rst_no | output | 1 | Target reset, active low |
| cfg_ss_no | output | 1 | Target slave select, active low |
| cfg_sck_o | output | 1 | Serial clock to target |
| cfg_sdo_o | output | 1 | Serial data to target |
| cfg_done_i | input | 1 | Target done flag |
| busy_o | output | 1 | Sequence in progress |
| ok_o | output | 1 | Sticky success flag, cleared by next start |
| err_reset_o | output | 1 | Sticky reset-check failure |
| err_done_o | output | 1 | Sticky done-check failure |

## Verification
A wrong sequencer state shows at the target pins within one system cycle. Slave select or reset take the wrong level, or serial clock edges appear during reset or the memory-clear wait. A bad phase or byte counter shows as a wrong number of rising edges in a slave-select-high spell, which is measurable once that spell ends. A bad shift register or bit counter shows as a corrupted byte recovered on rising edges by a target model, within eight serial clocks of the fault. A wrong done-flag decision shows as the wrong status flag when busy falls, and as a trailing spell of 104 clocks where 208 were expected, or the reverse.

// File: rtl/cfg_seq_pkg.sv
package cfg_seq_pkg;
  typedef enum logic [2:0] {
    ST_IDLE,
    ST_RST_LOW,
    ST_RST_WAIT,
    ST_PRE,
    ST_IMAGE,
    ST_POST,
    ST_ACT
  } cfg_state_e;
endpackage

// File: rtl/cfg_delay.sv
module cfg_delay #(
  parameter int W = 8
) (
  input  logic         clk_i,
  input  logic         rst_ni,
  input  logic         load_i,
  input  logic [W-1:0] value_i,
  output logic         zero_o
);
  logic [W-1:0] cnt_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)               cnt_q <= '0;
    else if (load_i)           cnt_q <= value_i;
    else if (cnt_q != '0)      cnt_q <= cnt_q - 1'b1;
  end

  assign zero_o = (cnt_q == '0);

  AST_TMR_HOLD_ZERO: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (zero_o && !load_i) |=> zero_o); // R3
endmodule

// File: rtl/cfg_spi_shift.sv
module cfg_spi_shift #(
  parameter int DIV = 4
) (
  input  logic       clk_i,
  input  logic       rst_ni,
  input  logic       load_i,
  input  logic [7:0] data_i,
  output logic       sck_o,
  output logic       sdo_o,
  output logic       busy_o,
  output logic       done_o
);
  localparam int HALF = (DIV < 2) ? 1 : DIV / 2;
  localparam int CW   = (HALF > 1) ? $clog2(HALF) : 1;

  logic          act_q, sck_q, done_q;
  logic [CW-1:0] cnt_q;
  logic [2:0]    bit_q;
  logic [7:0]    sh_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      act_q  <= 1'b0;
      sck_q  <= 1'b0;
      done_q <= 1'b0;
      cnt_q  <= '0;
      bit_q  <= '0;
      sh_q   <= '0;
    end else begin
      done_q <= 1'b0;
      if (load_i && !act_q) begin
        act_q <= 1'b1;
        sh_q  <= data_i;
        cnt_q <= '0;
        bit_q <= '0;
        sck_q <= 1'b0;
      end else if (act_q) begin
        if (cnt_q == CW'(HALF - 1)) begin
          cnt_q <= '0;
          if (!sck_q) begin
            sck_q <= 1'b1;
          end else begin
            // falling edge: advance data while clock is low
            sck_q <= 1'b0;
            if (bit_q == 3'd7) begin
              act_q  <= 1'b0;
              done_q <= 1'b1;
            end else begin
              bit_q <= bit_q + 1'b1;
              sh_q  <= {sh_q[6:0], 1'b0};
            end
          end
        end else begin
          cnt_q <= cnt_q + 1'b1;
        end
      end
    end
  end

  assign sck_o  = sck_q;
  assign sdo_o  = act_q & sh_q[7];
  assign busy_o = act_q;
  assign done_o = done_q;

  AST_SDO_HOLD_HIGH: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (sck_q && $past(sck_q)) |-> $stable(sdo_o)); // R6
  AST_SCK_IDLE_LOW: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !act_q |-> !sck_q); // R11
  AST_DONE_SINGLE: assert property (@(posedge clk_i) disable iff (!rst_ni)
    done_q |=> !done_q); // R11
endmodule

// File: rtl/fpga_cfg_seq.sv
module fpga_cfg_seq
  import cfg_seq_pkg::*;
#(
  parameter int CLK_HZ     = 100_000_000,
  parameter int SCK_DIV    = 4,
  parameter int RST_NS     = 200,
  parameter int WAIT_US    = 1200,
  parameter int PRE_BYTES  = 1,
  parameter int POST_BYTES = 13,
  parameter int ACT_BYTES  = 13
) (
  input  logic       clk_i,
  input  logic       rst_ni,
  input  logic       start_i,
  input  logic [7:0] byte_i,
  input  logic       byte_valid_i,
  input  logic       byte_last_i,
  output logic       byte_ready_o,
  output logic       cfg_rst_no,
  output logic       cfg_ss_no,
  output logic       cfg_sck_o,
  output logic       cfg_sdo_o,
  input  logic       cfg_done_i,
  output logic       busy_o,
  output logic       ok_o,
  output logic       err_reset_o,
  output logic       err_done_o
);
  localparam longint RST_RAW  = (longint'(CLK_HZ) * longint'(RST_NS) + 64'sd999_999_999) / 64'sd1_000_000_000;
  localparam longint WAIT_RAW = (longint'(CLK_HZ) * longint'(WAIT_US) + 64'sd999_999) / 64'sd1_000_000;
  localparam int RST_CYC  = (RST_RAW < 1) ? 1 : int'(RST_RAW);
  localparam int WAIT_CYC = (WAIT_RAW < 1) ? 1 : int'(WAIT_RAW);
  localparam int TMAX     = (RST_CYC > WAIT_CYC) ? RST_CYC : WAIT_CYC;
  localparam int TW       = $clog2(TMAX + 1);
  localparam int BMAX1    = (PRE_BYTES > POST_BYTES) ? PRE_BYTES : POST_BYTES;
  localparam int BMAX     = (BMAX1 > ACT_BYTES) ? BMAX1 : ACT_BYTES;
  localparam int NW       = $clog2(BMAX + 1);

  cfg_state_e    state_q;
  logic          kick_q, last_q;
  logic          ok_q, err_r_q, err_d_q;
  logic [NW-1:0] cnt_q, cnt_end;

  logic          tmr_load, tmr_zero;
  logic [TW-1:0] tmr_val;
  logic          sh_load, sh_busy, sh_done;
  logic [7:0]    sh_data;

  cfg_delay #(.W(TW)) u_dly (
    .clk_i   (clk_i),
    .rst_ni  (rst_ni),
    .load_i  (tmr_load),
    .value_i (tmr_val),
    .zero_o  (tmr_zero)
  );

  cfg_spi_shift #(.DIV(SCK_DIV)) u_shf (
    .clk_i  (clk_i),
    .rst_ni (rst_ni),
    .load_i (sh_load),
    .data_i (sh_data),
    .sck_o  (cfg_sck_o),
    .sdo_o  (cfg_sdo_o),
    .busy_o (sh_busy),
    .done_o (sh_done)
  );

  always_comb begin
    unique case (state_q)
      ST_PRE:  cnt_end = NW'(PRE_BYTES - 1);
      ST_POST: cnt_end = NW'(POST_BYTES - 1);
      default: cnt_end = NW'(ACT_BYTES - 1);
    endcase
  end

  always_comb begin
    tmr_load     = 1'b0;
    tmr_val      = '0;
    sh_load      = 1'b0;
    sh_data      = 8'h00;
    byte_ready_o = 1'b0;
    unique case (state_q)
      ST_IDLE: if (start_i) begin
        tmr_load = 1'b1;
        tmr_val  = TW'(RST_CYC);
      end
      ST_RST_LOW: if (tmr_zero) begin
        tmr_load = 1'b1;
        tmr_val  = TW'(WAIT_CYC);
      end
      ST_PRE, ST_POST, ST_ACT:
        sh_load = kick_q || (sh_done && cnt_q != cnt_end);
      ST_IMAGE: begin
        byte_ready_o = !sh_busy && !last_q;
        sh_load      = byte_valid_i && byte_ready_o;
        sh_data      = byte_i;
      end
      default: ;
    endcase
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      state_q <= ST_IDLE;
      kick_q  <= 1'b0;
      last_q  <= 1'b0;
      cnt_q   <= '0;
      ok_q    <= 1'b0;
      err_r_q <= 1'b0;
      err_d_q <= 1'b0;
    end else begin
      kick_q <= 1'b0;
      unique case (state_q)
        ST_IDLE: if (start_i) begin
          state_q <= ST_RST_LOW;
          ok_q    <= 1'b0;
          err_r_q <= 1'b0;
          err_d_q <= 1'b0;
        end
        ST_RST_LOW: if (tmr_zero) state_q <= ST_RST_WAIT;
        ST_RST_WAIT: if (tmr_zero) begin
          if (cfg_done_i) begin
            err_r_q <= 1'b1;
            state_q <= ST_IDLE;
          end else begin
            state_q <= ST_PRE;
            kick_q  <= 1'b1;
            cnt_q   <= '0;
          end
        end
        ST_PRE: if (sh_done) begin
          if (cnt_q == cnt_end) begin
            state_q <= ST_IMAGE;
            last_q  <= 1'b0;
          end else cnt_q <= cnt_q + 1'b1;
        end
        ST_IMAGE: begin
          if (sh_load && byte_last_i) last_q <= 1'b1;
          if (sh_done && last_q) begin
            state_q <= ST_POST;
            kick_q  <= 1'b1;
            cnt_q   <= '0;
          end
        end
        ST_POST: if (sh_done) begin
          if (cnt_q == cnt_end) begin
            cnt_q <= '0;
            if (cfg_done_i) begin
              state_q <= ST_ACT;
              kick_q  <= 1'b1;
            end else begin
              err_d_q <= 1'b1;
              state_q <= ST_IDLE;
            end
          end else cnt_q <= cnt_q + 1'b1;
        end
        ST_ACT: if (sh_done) begin
          if (cnt_q == cnt_end) begin
            ok_q    <= 1'b1;
            state_q <= ST_IDLE;
          end else cnt_q <= cnt_q + 1'b1;
        end
        default: state_q <= ST_IDLE;
      endcase
    end
  end

  assign cfg_rst_no  = (state_q != ST_RST_LOW);
  assign cfg_ss_no   = !(state_q inside {ST_RST_LOW, ST_RST_WAIT, ST_IMAGE});
  assign busy_o      = (state_q != ST_IDLE);
  assign ok_o        = ok_q;
  assign err_reset_o = err_r_q;
  assign err_done_o  = err_d_q;

  AST_RST_WITH_SS: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $fell(cfg_rst_no) |-> !cfg_ss_no); // R2
  AST_NO_SCK_IN_RESET: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !cfg_rst_no |-> !cfg_sck_o); // R3
  AST_READY_SS_LOW: assert property (@(posedge clk_i) disable iff (!rst_ni)
    byte_ready_o |-> (!cfg_ss_no && !cfg_sck_o)); // R6
  AST_STATUS_ONEHOT: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $onehot0({ok_q, err_r_q, err_d_q})); // R9
  AST_BUSY_NO_STATUS: assert property (@(posedge clk_i) disable iff (!rst_ni)
    busy_o |-> !(ok_q || err_r_q || err_d_q)); // R10
  AST_SS_STABLE_SCK_HIGH: assert property (@(posedge clk_i) disable iff (!rst_ni)
    cfg_sck_o |-> $stable(cfg_ss_no)); // R6
endmodule

// File: tb/sim_fpga_cfg_seq.sv
module sim_fpga_cfg_seq;
  localparam int CLK_HZ  = 1_000_000;
  localparam int SCK_DIV = 4;

  logic clk = 1'b0, rst_n = 1'b0;
  logic start_i = 1'b0, byte_valid_i = 1'b0, byte_last_i = 1'b0, cfg_done_i = 1'b0;
  logic [7:0] byte_i = 8'h00;
  logic byte_ready_o, cfg_rst_no, cfg_ss_no, cfg_sck_o, cfg_sdo_o;
  logic busy_o, ok_o, err_reset_o, err_done_o;

  always #5 clk = ~clk;

  fpga_cfg_seq #(.CLK_HZ(CLK_HZ), .SCK_DIV(SCK_DIV)) u0 (
    .clk_i(clk), .rst_ni(rst_n), .start_i(start_i), .byte_i(byte_i),
    .byte_valid_i(byte_valid_i), .byte_last_i(byte_last_i), .byte_ready_o(byte_ready_o),
    .cfg_rst_no(cfg_rst_no), .cfg_ss_no(cfg_ss_no), .cfg_sck_o(cfg_sck_o),
    .cfg_sdo_o(cfg_sdo_o), .cfg_done_i(cfg_done_i), .busy_o(busy_o), .ok_o(ok_o),
    .err_reset_o(err_reset_o), .err_done_o(err_done_o)
  );

  int n_chk = 0, n_bad = 0;
  int mode = 0, len = 0, stall_at = 99;
  bit rnd_stall = 0;
  logic [7:0] tx [0:31];
  logic [7:0] rx [0:31];

  function automatic int exp_rst_cyc();
    longint v = (longint'(CLK_HZ) * 200 + 999_999_999) / 1_000_000_000;
    return (v < 1) ? 1 : int'(v);
  endfunction
  function automatic int exp_wait_cyc();
    longint v = (longint'(CLK_HZ) * 1200 + 999_999) / 1_000_000;
    return int'(v);
  endfunction
  function automatic int exp_tail(int m);
    return (m == 0) ? 8 * 26 : 8 * 13;
  endfunction

  task automatic chk(bit ok, string req, int act, int exp);
    n_chk++;
    if (!ok) begin
      n_bad++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  // target model and pin monitor
  int rst_low, rst_falls, wait_cyc, nspell, spell0, spell1, dummy_nz, bits;
  int short_per, since_rise, win_sck, win_ss, early_sck, cyc = 0;
  bit ss_fall_ok, win_on = 0;
  logic prev_sck = 0, prev_ss = 1, prev_rst = 1;
  logic [7:0] cur;

  always @(negedge clk) begin
    cyc++;
    if (start_i && !busy_o) begin
      rst_low = 0; rst_falls = 0; wait_cyc = 0; nspell = 0; spell0 = 0; spell1 = 0;
      dummy_nz = 0; bits = 0; short_per = 0; since_rise = SCK_DIV; win_sck = 0;
      win_ss = 0; early_sck = 0; ss_fall_ok = 1; cur = 8'h00;
    end else begin
      if (since_rise < 1000) since_rise++;
      if (!cfg_rst_no) rst_low++;
      if (prev_rst && !cfg_rst_no) begin
        rst_falls++;
        if (cfg_ss_no) ss_fall_ok = 0;
      end
      if (busy_o && cfg_rst_no && !cfg_ss_no && nspell == 0) wait_cyc++;
      if (cfg_ss_no && !prev_ss && busy_o) nspell++;
      if (cfg_sck_o && !prev_sck) begin
        if (since_rise < SCK_DIV) short_per++;
        since_rise = 0;
        if (win_on) win_sck++;
        if (!cfg_rst_no || nspell == 0) early_sck++;
        else if (cfg_ss_no) begin
          if (nspell == 1) spell0++; else spell1++;
          if (cfg_sdo_o) dummy_nz++;
        end else begin
          cur = {cur[6:0], cfg_sdo_o};
          bits++;
          if (bits % 8 == 0 && bits <= 256) rx[bits/8-1] = cur;
        end
      end
      if (win_on && cfg_ss_no) win_ss++;
    end
    prev_sck = cfg_sck_o; prev_ss = cfg_ss_no; prev_rst = cfg_rst_no;
    cfg_done_i = (mode == 1) || (mode == 0 && len > 0 && bits >= len * 8);
    if (cyc > 150_000) begin
      n_chk++; n_bad++;
      $display("FAIL watchdog actual=%0d expected=%0d", cyc, 150_000);
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
      $finish;
    end
  end

  // byte source
  int idx = 0, hold = 0;
  bit pend = 0, stalled = 0;
  always @(negedge clk) begin
    if (start_i && !busy_o) begin
      idx = 0; pend = 0; stalled = 0; hold = 0; win_on = 0;
      byte_valid_i = 0;
    end else begin
      if (pend) idx++;
      if (hold > 0) hold--;
      win_on = (hold > 0 && hold < 100);
      if (idx == stall_at && !stalled && stall_at < len) begin
        stalled = 1; hold = 170;
      end
      byte_valid_i = (idx < len) && hold == 0 && (!rnd_stall || ($urandom % 3) != 0);
      byte_i = (idx < len) ? tx[idx] : 8'h00;
      byte_last_i = (idx == len - 1);
      pend = byte_valid_i && byte_ready_o;
    end
  end

  task automatic run(int m, int n, bit rs, int sa, string tag);
    mode = m; len = n; rnd_stall = rs; stall_at = sa;
    @(negedge clk); start_i = 1;
    @(negedge clk); start_i = 0;
    repeat (100) @(negedge clk);
    start_i = 1;                       // R10: ignored while busy
    @(negedge clk); start_i = 0;
    while (busy_o) @(negedge clk);
    repeat (2) @(negedge clk);
    $display("run %s", tag);
    chk(rst_falls == 1, "R10 reset falls once", rst_falls, 1);
    chk(ss_fall_ok, "R2 ss low with reset", ss_fall_ok, 1);
    chk(rst_low >= exp_rst_cyc(), "R2 reset low time", rst_low, exp_rst_cyc());
    chk(wait_cyc >= exp_wait_cyc(), "R3 clear wait", wait_cyc, exp_wait_cyc());
    chk(early_sck == 0, "R3 no clock in reset/wait", early_sck, 0);
    chk(short_per == 0, "R11 clock period", short_per, 0);
    chk(cfg_sck_o == 0 && cfg_ss_no == 1, "R11 idle pins", cfg_sck_o, 0);
    if (m == 1) begin
      chk(err_reset_o && !ok_o && !err_done_o, "R4 reset-check error", err_reset_o, 1);
      chk(nspell == 0 && bits == 0, "R4 no clocks", bits + nspell, 0);
    end else begin
      chk(spell0 == 8, "R5 pre dummy clocks", spell0, 8);
      chk(dummy_nz == 0, "R5 R8 dummy data zero", dummy_nz, 0);
      chk(bits == n * 8, "R6 image bit count", bits, n * 8);
      for (int i = 0; i < n; i++)
        chk(rx[i] == tx[i], "R6 image byte MSB first", rx[i], tx[i]);
      chk(spell1 == exp_tail(m), m == 0 ? "R9 tail clocks" : "R8 tail clocks", spell1, exp_tail(m));
      if (m == 0) chk(ok_o && !err_done_o && !err_reset_o, "R9 success flag", ok_o, 1);
      else        chk(err_done_o && !ok_o && !err_reset_o, "R8 done-check error", err_done_o, 1);
    end
    if (sa < n) begin
      chk(win_sck == 0, "R7 no clock during stall", win_sck, 0);
      chk(win_ss == 0, "R7 ss low during stall", win_ss, 0);
    end
  endtask

  initial begin
    void'($urandom(32'd4242));
    repeat (3) @(negedge clk);
    chk(cfg_rst_no == 1 && cfg_ss_no == 1, "R1 reset pins", {cfg_rst_no, cfg_ss_no}, 3);
    chk(cfg_sck_o == 0 && busy_o == 0, "R1 idle clock/busy", {cfg_sck_o, busy_o}, 0);
    chk({ok_o, err_reset_o, err_done_o} == 3'b000, "R1 status clear", {ok_o, err_reset_o, err_done_o}, 0);
    rst_n = 1;
    repeat (2) @(negedge clk);
    chk(cfg_rst_no == 1 && busy_o == 0, "R1 after release", busy_o, 0);

    tx[0] = 8'h80; tx[1] = 8'h01; tx[2] = 8'hFF; tx[3] = 8'h00; tx[4] = 8'hA5;
    run(0, 5, 0, 99, "directed success");
    run(1, 4, 0, 99, "reset check error");
    for (int i = 0; i < 3; i++) tx[i] = 8'($urandom);
    run(2, 3, 0, 99, "done check error");
    for (int i = 0; i < 16; i++) tx[i] = 8'($urandom);
    run(0, 16, 1, 6, "random stalls with long stall");
    tx[0] = 8'h5C;
    run(0, 1, 0, 99, "single byte image");
    begin
      int n = 2 + int'($urandom % 19);
      for (int i = 0; i < n; i++) tx[i] = 8'($urandom);
      run(0, n, 1, 99, "random length");
    end
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
    $finish;
  end
endmodule